// File: doc/BRIEF.md
# Warp Issue Scheduler with Latency Hiding

This block sits in one compute unit and keeps a small record for every warp slot the unit can hold. A warp is a group of 32 threads with consecutive thread indices: threads 0–31 form warp 0, threads 32–63 form warp 1, and so on. A thread block of N threads therefore occupies N/32 slots, and the number of occupied slots is the warps per block times the number of blocks held. Each cycle the scheduler picks at most one warp whose next instruction may be issued, and reports its slot number with a valid flag.

A warp that has started a long-latency operation, such as a memory load, is set aside until the result comes back, and the other ready warps fill the stall. The instruction source raises a per-warp marker when the warp being issued starts such an operation. The memory side raises a per-warp completion when the result returns. The residency mask says which slots hold a live warp. When several warps are ready, a rotating priority picks one. A parameter can select a fixed lowest-index priority instead.

Top module: `warp_issue_sched`

## Requirements
- R1: An issued warp is always resident, and it is either not waiting or has its completion raised in that same cycle.
- R2: A resident warp whose long-latency marker is high at a clock edge is waiting from the next cycle on, and it cannot issue until its completion returns.
- R3: A completion makes the warp eligible in the same cycle it is raised, and the waiting state is gone from the next cycle on.
- R4: When marker and completion are both high for one warp in the same cycle, that warp is eligible in that cycle and is waiting from the next cycle on.
- R5: With rotating priority (ROUND_ROBIN=1), the search begins at the slot after the last issued one and wraps from NUM_WARPS-1 to 0. The pointer does not move in a cycle with no issue.
- R6: When no warp is eligible, the issue valid output is 0 and the warp ID output is 0.
- R7: After reset no warp is waiting, and the first search begins at slot 0.
- R8: A slot that is not resident loses any waiting state at the next edge, and a marker on a non-resident slot is ignored.
- R9: At most one warp issues per cycle, and the issued ID is always below NUM_WARPS. The ID is 5 bits wide. NUM_WARPS must lie between 2 and 32, which is checked at elaboration.
- R10: With fixed priority (ROUND_ROBIN=0), the lowest-numbered eligible slot always wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| resident_i | input | NUM_WARPS | Bit w high: slot w holds a live warp |
| long_mark_i | input | NUM_WARPS | Bit w high: warp w starts a long-latency operation this cycle |
| long_done_i | input | NUM_WARPS | Bit w high: warp w's long-latency result returns this cycle |
| issue_valid_o | output | 1 | A warp is issued this cycle |
| issue_wid_o | output | 5 | Slot number of the issued warp, 0 when none |

## Verification
The hardest situation to reach from the ports is a cycle in which every resident warp is stalled. That cycle must then be followed by one in which a single completion both revives a warp and sends the rotating search past several stalled slots. The stimulus table reaches it by marking each issued warp in turn until all four are waiting. It then returns completions one at a time, so the pointer position and the set of waiting warps are known exactly at each step. Further table rows cover a marker and a completion on the same warp in one cycle, and a slot that retires while stalled. Directed steps check that reset clears all stalls, and that a second instance using fixed priority picks the lowest slot.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;
   localparam int MAX_WARPS = 32;
   localparam int WID_W     = 5;
   typedef logic [WID_W-1:0] wid_t;
endpackage

// File: rtl/warp_wait_track.sv
module warp_wait_track #(
   parameter int NUM_WARPS = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WARPS-1:0] resident_i,
   input  logic [NUM_WARPS-1:0] long_mark_i,
   input  logic [NUM_WARPS-1:0] long_done_i,
   output logic [NUM_WARPS-1:0] eligible_o
);
   logic [NUM_WARPS-1:0] stall_q;

   for (genvar w = 0; w < NUM_WARPS; w++) begin : g_slot
      logic stall_d;
      always_comb begin
         stall_d = resident_i[w] & ((stall_q[w] & ~long_done_i[w]) | long_mark_i[w]);
      end

      always_ff @(posedge clk) begin
         if (!rst_n) stall_q[w] <= 1'b0;
         else        stall_q[w] <= stall_d;
      end

      assign eligible_o[w] = resident_i[w] & (~stall_q[w] | long_done_i[w]);

      // R2
      mark_sets_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (long_mark_i[w] && resident_i[w]) |=> stall_q[w]);
      // R3
      done_clears_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (long_done_i[w] && !long_mark_i[w]) |=> !stall_q[w]);
      // R8
      retired_clears_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !resident_i[w] |=> !stall_q[w]);
   end
endmodule

// File: rtl/warp_pick_arb.sv
module warp_pick_arb
   import warp_sched_pkg::*;
#(
   parameter int NUM_WARPS   = 8,
   parameter bit ROUND_ROBIN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WARPS-1:0] eligible_i,
   output logic                 pick_valid_o,
   output wid_t                 pick_wid_o
);
   localparam int LAST = NUM_WARPS - 1;

   logic found;
   wid_t sel;

   if (ROUND_ROBIN) begin : g_rr
      wid_t last_q;

      always_comb begin
         found = 1'b0;
         sel   = '0;
         for (int i = 0; i < NUM_WARPS; i++) begin
            int k;
            k = int'(last_q) + 1 + i;
            if (k >= NUM_WARPS) k = k - NUM_WARPS;
            if (k >= NUM_WARPS) k = k - NUM_WARPS;
            if (!found && eligible_i[k]) begin
               found = 1'b1;
               sel   = wid_t'(k);
            end
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n)     last_q <= wid_t'(LAST);
         else if (found) last_q <= sel;
      end

      // R5
      ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !pick_valid_o |=> $stable(last_q));
   end else begin : g_fixed
      always_comb begin
         found = 1'b0;
         sel   = '0;
         for (int k = NUM_WARPS - 1; k >= 0; k--) begin
            if (eligible_i[k]) begin
               found = 1'b1;
               sel   = wid_t'(k);
            end
         end
      end
   end

   assign pick_valid_o = found;
   assign pick_wid_o   = sel;

   // R6
   idle_wid_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pick_valid_o |-> (pick_wid_o == '0));
   // R9
   wid_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pick_valid_o |-> (int'(pick_wid_o) < NUM_WARPS));
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
   import warp_sched_pkg::*;
#(
   parameter int NUM_WARPS   = 8,
   parameter bit ROUND_ROBIN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_WARPS-1:0] resident_i,
   input  logic [NUM_WARPS-1:0] long_mark_i,
   input  logic [NUM_WARPS-1:0] long_done_i,
   output logic                 issue_valid_o,
   output logic [WID_W-1:0]     issue_wid_o
);
   // R9: elaboration-time bound on the slot count
   if (NUM_WARPS < 2 || NUM_WARPS > MAX_WARPS) begin : g_bad_count
      $error("warp_issue_sched: NUM_WARPS must be within 2..32");
   end

   logic [NUM_WARPS-1:0] eligible;

   warp_wait_track #(.NUM_WARPS(NUM_WARPS)) i_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .resident_i  (resident_i),
      .long_mark_i (long_mark_i),
      .long_done_i (long_done_i),
      .eligible_o  (eligible)
   );

   warp_pick_arb #(.NUM_WARPS(NUM_WARPS), .ROUND_ROBIN(ROUND_ROBIN)) i_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .eligible_i   (eligible),
      .pick_valid_o (issue_valid_o),
      .pick_wid_o   (issue_wid_o)
   );

   // R1
   issue_resident_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid_o |-> resident_i[issue_wid_o]);
   // R1
   issue_not_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid_o |-> eligible[issue_wid_o]);
endmodule

// File: tb/test_warp_issue_sched.sv
module test_warp_issue_sched;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] res = '0, mark = '0, done = '0;
   logic         vld, vld_f;
   logic [4:0]   wid, wid_f;
   int           checks = 0, errors = 0;
   bit           finished = 1'b0;

   always #4 clk = ~clk;

   warp_issue_sched #(.NUM_WARPS(N), .ROUND_ROBIN(1'b1)) i_warp_issue_sched (
      .clk(clk), .rst_n(rst_n), .resident_i(res), .long_mark_i(mark),
      .long_done_i(done), .issue_valid_o(vld), .issue_wid_o(wid));

   warp_issue_sched #(.NUM_WARPS(N), .ROUND_ROBIN(1'b0)) i_warp_issue_sched_fixed (
      .clk(clk), .rst_n(rst_n), .resident_i(res), .long_mark_i(mark),
      .long_done_i(done), .issue_valid_o(vld_f), .issue_wid_o(wid_f));

   // fields: resident, marker, completion, expected valid, expected ID
   localparam logic [17:0] VEC [21] = '{
      {4'b1111, 4'b0000, 4'b0000, 1'b1, 5'd0},  // R5 R7 first pick slot 0
      {4'b1111, 4'b0010, 4'b0000, 1'b1, 5'd1},  // R2 mark warp 1
      {4'b1111, 4'b0100, 4'b0000, 1'b1, 5'd2},  // R1 skip 1, mark 2
      {4'b1111, 4'b0000, 4'b0000, 1'b1, 5'd3},
      {4'b1111, 4'b0001, 4'b0000, 1'b1, 5'd0},  // R5 wrap
      {4'b1111, 4'b0000, 4'b0000, 1'b1, 5'd3},  // R1 only 3 ready
      {4'b1111, 4'b1000, 4'b0000, 1'b1, 5'd3},  // mark last free warp
      {4'b1111, 4'b0000, 4'b0000, 1'b0, 5'd0},  // R6 all stalled
      {4'b1111, 4'b0000, 4'b0100, 1'b1, 5'd2},  // R3 same-cycle wake
      {4'b1111, 4'b0000, 4'b0001, 1'b1, 5'd0},  // R3 R5 search from 3
      {4'b1111, 4'b0000, 4'b0000, 1'b1, 5'd2},  // R3 warp 2 stays ready
      {4'b1011, 4'b0000, 4'b0000, 1'b1, 5'd0},  // R8 slot 2 retired
      {4'b0000, 4'b1111, 4'b0000, 1'b0, 5'd0},  // R6 R8 none resident
      {4'b1010, 4'b0000, 4'b0000, 1'b1, 5'd1},  // R8 stalls dropped
      {4'b1010, 4'b0000, 4'b0000, 1'b1, 5'd3},
      {4'b1010, 4'b0000, 4'b0000, 1'b1, 5'd1},
      {4'b1111, 4'b0100, 4'b0100, 1'b1, 5'd2},  // R4 mark+done same cycle
      {4'b1111, 4'b0000, 4'b0000, 1'b1, 5'd3},
      {4'b1111, 4'b0000, 4'b0000, 1'b1, 5'd0},
      {4'b1111, 4'b0000, 4'b0000, 1'b1, 5'd1},
      {4'b1111, 4'b0000, 4'b0000, 1'b1, 5'd3}   // R4 warp 2 now waiting
   };

   task automatic check(input string req, input logic av, input logic [4:0] aw,
                        input logic ev, input logic [4:0] ew);
      checks++;
      if (av !== ev || aw !== ew) begin
         errors++;
         $display("FAIL %s: got valid=%0b id=%0d, expected valid=%0b id=%0d",
                  req, av, aw, ev, ew);
      end
   endtask

   task automatic drive(input logic [N-1:0] r, input logic [N-1:0] m, input logic [N-1:0] d);
      @(negedge clk);
      res = r; mark = m; done = d;
      #1;
   endtask

   initial begin
      #(8 * 20000);
      if (!finished) begin
         checks++; errors++;
         $display("FAIL watchdog: got no finish, expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      drive('0, '0, '0);
      check("R7 R6 idle during reset", vld, wid, 1'b0, 5'd0);
      rst_n = 1'b1;
      #1;
      check("R6 no resident after reset", vld, wid, 1'b0, 5'd0);

      for (int i = 0; i < 21; i++) begin
         drive(VEC[i][17:14], VEC[i][13:10], VEC[i][9:6]);
         check($sformatf("vector %0d", i), vld, wid, VEC[i][5], VEC[i][4:0]);
      end

      // R2: stall every warp, verify nothing issues
      drive(4'b1111, 4'b1111, 4'b0000);
      drive(4'b1111, 4'b0000, 4'b0000);
      check("R2 all marked, none issues", vld, wid, 1'b0, 5'd0);
      check("R10 fixed also stalled", vld_f, wid_f, 1'b0, 5'd0);
      // R7: reset clears stalls and restarts at slot 0
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1; #1;
      check("R7 slot 0 first after reset", vld, wid, 1'b1, 5'd0);
      check("R10 fixed lowest slot", vld_f, wid_f, 1'b1, 5'd0);
      drive(4'b1111, 4'b0000, 4'b0000);
      check("R5 rotation continues", vld, wid, 1'b1, 5'd1);
      check("R10 fixed stays at 0", vld_f, wid_f, 1'b1, 5'd0);
      drive(4'b1100, 4'b0000, 4'b0000);
      check("R10 fixed lowest resident", vld_f, wid_f, 1'b1, 5'd2);
      // R8: marker on a non-resident slot is ignored
      drive(4'b1100, 4'b0011, 4'b0000);
      drive(4'b0011, 4'b0000, 4'b0000);
      check("R8 R10 ignored marker", vld_f, wid_f, 1'b1, 5'd0);

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule